// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit processor core and a memory that is one word wide. The core hands it one memory access at a time. Each access has an opcode, a base register value, a 16-bit immediate and, for stores, the source register value. The unit adds the sign-extended immediate to the base to form the byte address, and drives a word-aligned address to memory. Bytes are numbered big-endian: byte offset 0 inside a word is bits 31:24 and offset 3 is bits 7:0.

For a store, the unit places the source bytes on the right lanes and raises only the byte enables that the access covers. For a load, it picks the addressed byte or halfword out of the returned word and widens it to 32 bits, with sign or zero extension. It checks halfword and word addresses for alignment. A misaligned access never reaches memory. Instead it raises a one-cycle exception with code 4 for a load or code 5 for a store.

A small state machine runs each access. The states are `ST_IDLE`, `ST_ISSUE`, `ST_LDRET`, `ST_STDONE` and `ST_FAULT`. An accepted request moves `ST_IDLE` to `ST_ISSUE`. From `ST_ISSUE` the machine goes to `ST_FAULT` when the address is misaligned, to `ST_LDRET` for an aligned load, and to `ST_STDONE` for an aligned store. Each of those three states returns to `ST_IDLE` after one cycle.

Top module: `lsu_align_be`

## Requirements
- R1: The byte address is `req_base` plus the immediate sign-extended to the address width. During the issue cycle, `mem_addr` carries that address with bits 1:0 cleared.
- R2: Byte store, opcode 0x28 (`sb`): at byte offset k, the single enable `mem_be[3-k]` is high and the other three are low, and every lane of `mem_wdata` holds bits 7:0 of the source. Lanes whose enable is low are don't-care.
- R3: Halfword store, opcode 0x29 (`sh`): offset 0 gives `mem_be` = 4'b1100 and offset 2 gives 4'b0011. Bits 15:0 of the source appear on both halves of `mem_wdata`.
- R4: Word store, opcode 0x2B (`sw`): `mem_be` = 4'b1111 and `mem_wdata` equals the source.
- R5: Byte loads: `lb` (0x20) and `lbu` (0x24) return the byte at bits (31-8k):(24-8k) of the memory word for offset k. `lb` sign-extends it and `lbu` zero-extends it.
- R6: Halfword loads: `lh` (0x21) and `lhu` (0x25) return bits 31:16 at offset 0 and bits 15:0 at offset 2. `lh` sign-extends and `lhu` zero-extends.
- R7: Word load, opcode 0x23 (`lw`): returns the whole memory word.
- R8: A halfword load at an odd address, or a word load with address bits 1:0 not zero, makes no memory read. It raises `exc_valid` for one cycle with `exc_code` = 4 and no `rsp_valid`.
- R9: A misaligned store (same alignment rules as R8) keeps `mem_we` low and `mem_be` at 0. It raises `exc_valid` for one cycle with `exc_code` = 5, and memory is left unchanged.
- R10: A request whose opcode is not one of the eight above is ignored. The unit makes no memory access, gives no response and no exception, and `req_ready` stays high.
- R11: The unit accepts a request only while `req_ready` is high. The memory access happens in the cycle after acceptance, and a response or exception is shown in the cycle after that, for exactly one cycle. `req_ready` is high again in the next cycle.
- R12: While reset is held, `req_ready` is high and `mem_re`, `mem_we`, `mem_be`, `rsp_valid` and `exc_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Unit is idle and can take a request |
| req_op | input | 6 | Primary opcode of the access |
| req_base | input | ADDR_W | Base register value |
| req_imm | input | 16 | Immediate offset |
| req_wdata | input | 32 | Source register value for stores |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables; bit 3 covers bits 31:24 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 32 | Extended load result (zero for stores) |
| exc_valid | output | 1 | Address-error exception |
| exc_code | output | 5 | 4 for a load, 5 for a store, 0 when idle |

## Verification
Alignment checking and store-lane generation both act in the issue cycle. A misaligned store therefore has to cancel enables that the lane logic has already computed. The bench provokes this with halfword and word stores at odd or unaligned offsets that carry random data. It judges each one by three things: `mem_be` at zero with `mem_we` low in that cycle, code 5 in the next cycle, and a later load from the same word that returns the untouched contents.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned EXC_W  = 5;

    localparam logic [5:0] OPC_LB  = 6'h20;
    localparam logic [5:0] OPC_LH  = 6'h21;
    localparam logic [5:0] OPC_LW  = 6'h23;
    localparam logic [5:0] OPC_LBU = 6'h24;
    localparam logic [5:0] OPC_LHU = 6'h25;
    localparam logic [5:0] OPC_SB  = 6'h28;
    localparam logic [5:0] OPC_SH  = 6'h29;
    localparam logic [5:0] OPC_SW  = 6'h2B;

    localparam logic [EXC_W-1:0] EXC_NONE     = 5'd0;
    localparam logic [EXC_W-1:0] EXC_ADR_LOAD = 5'd4;
    localparam logic [EXC_W-1:0] EXC_ADR_STOR = 5'd5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      valid;
        logic      is_store;
        logic      sign_ext;
        acc_size_e size;
    } acc_decode_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_LDRET  = 3'd2,
        ST_STDONE = 3'd3,
        ST_FAULT  = 3'd4
    } lsu_state_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [5:0]  op_i,
    output acc_decode_t dec_o
);

    always_comb begin
        dec_o = '{valid: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
        unique case (op_i)
            OPC_LB:  dec_o = '{valid: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
            OPC_LBU: dec_o = '{valid: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
            OPC_LH:  dec_o = '{valid: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
            OPC_LHU: dec_o = '{valid: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
            OPC_LW:  dec_o = '{valid: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
            OPC_SB:  dec_o = '{valid: 1'b1, is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
            OPC_SH:  dec_o = '{valid: 1'b1, is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
            OPC_SW:  dec_o = '{valid: 1'b1, is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
            default: ;
        endcase
    end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  acc_size_e         size_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              misaligned_o
);

    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_sext;

    assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign ea_o     = base_i + imm_sext;

    always_comb begin
        unique case (size_i)
            SZ_HALF: misaligned_o = ea_o[0];
            SZ_WORD: misaligned_o = |ea_o[OFF_W-1:0];
            default: misaligned_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] data_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int unsigned    HI   = DATA_W - 1 - 8 * k;
        localparam logic [OFF_W-1:0] KOFF = OFF_W'(k);

        always_comb begin
            unique case (size_i)
                SZ_BYTE: begin
                    be_o[LANES-1-k]  = (offset_i == KOFF);
                    data_o[HI -: 8]  = src_i[7:0];
                end
                SZ_HALF: begin
                    be_o[LANES-1-k]  = (offset_i[1] == KOFF[1]);
                    data_o[HI -: 8]  = KOFF[0] ? src_i[7:0] : src_i[15:8];
                end
                default: begin
                    be_o[LANES-1-k]  = 1'b1;
                    data_o[HI -: 8]  = src_i[HI -: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  acc_size_e         size_i,
    input  logic              sign_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] result_o
);

    logic [7:0]  lane_b [LANES];
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    for (genvar k = 0; k < LANES; k++) begin : g_split
        localparam int unsigned HI = DATA_W - 1 - 8 * k;
        assign lane_b[k] = word_i[HI -: 8];
    end

    assign sel_byte = lane_b[offset_i];
    assign sel_half = {lane_b[{offset_i[1], 1'b0}], lane_b[{offset_i[1], 1'b1}]};

    always_comb begin
        unique case (size_i)
            SZ_BYTE: result_o = {{(DATA_W-8){sign_i & sel_byte[7]}}, sel_byte};
            SZ_HALF: result_o = {{(DATA_W-16){sign_i & sel_half[15]}}, sel_half};
            default: result_o = word_i;
        endcase
    end

endmodule

// File: rtl/lsu_align_be.sv
module lsu_align_be
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [5:0]        req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [15:0]       req_imm,
    input  logic [31:0]       req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              exc_valid,
    output logic [4:0]        exc_code
);

    lsu_state_e        state_q, state_d;
    acc_decode_t       in_dec;
    logic              accept;

    logic              is_store_q;
    logic              sign_q;
    acc_size_e         size_q;
    logic [ADDR_W-1:0] base_q;
    logic [IMM_W-1:0]  imm_q;
    logic [DATA_W-1:0] wdata_q;

    logic [ADDR_W-1:0] ea;
    logic              misal;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_data;
    logic [DATA_W-1:0] ld_result;

    lsu_decode u_dec (
        .op_i  (req_op),
        .dec_o (in_dec)
    );

    assign accept = (state_q == ST_IDLE) && req_valid && in_dec.valid;

    lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base_i       (base_q),
        .imm_i        (imm_q),
        .size_i       (size_q),
        .ea_o         (ea),
        .misaligned_o (misal)
    );

    lsu_store_lanes u_st (
        .size_i   (size_q),
        .offset_i (ea[OFF_W-1:0]),
        .src_i    (wdata_q),
        .be_o     (st_be),
        .data_o   (st_data)
    );

    lsu_load_extract u_ld (
        .size_i   (size_q),
        .sign_i   (sign_q),
        .offset_i (ea[OFF_W-1:0]),
        .word_i   (mem_rdata),
        .result_o (ld_result)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_store_q <= 1'b0;
            sign_q     <= 1'b0;
            size_q     <= SZ_BYTE;
            base_q     <= '0;
            imm_q      <= '0;
            wdata_q    <= '0;
        end else if (accept) begin
            is_store_q <= in_dec.is_store;
            sign_q     <= in_dec.sign_ext;
            size_q     <= in_dec.size;
            base_q     <= req_base;
            imm_q      <= req_imm;
            wdata_q    <= req_wdata;
        end
    end

    assign mem_addr  = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = st_data;

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        exc_valid = 1'b0;
        exc_code  = EXC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (misal) begin
                    state_d = ST_FAULT;
                end else if (is_store_q) begin
                    mem_we  = 1'b1;
                    mem_be  = st_be;
                    state_d = ST_STDONE;
                end else begin
                    mem_re  = 1'b1;
                    state_d = ST_LDRET;
                end
            end
            ST_LDRET: begin
                rsp_valid = 1'b1;
                rsp_rdata = ld_result;
                state_d   = ST_IDLE;
            end
            ST_STDONE: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_FAULT: begin
                exc_valid = 1'b1;
                exc_code  = is_store_q ? EXC_ADR_STOR : EXC_ADR_LOAD;
                state_d   = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/lsu_align_be_chk.sv
module lsu_align_be_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic [1:0] mem_addr_lo,
    input logic       mem_re,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       rsp_valid,
    input logic       exc_valid,
    input logic [4:0] exc_code
);

    assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (mem_addr_lo == 2'b00));

    assert_be_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be inside {4'b1000, 4'b0100, 4'b0010, 4'b0001,
                                   4'b1100, 4'b0011, 4'b1111}));

    assert_be_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == 4'b0000));

    assert_read_then_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (rsp_valid && !exc_valid));

    assert_write_then_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (rsp_valid && !exc_valid));

    assert_exc_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code == 5'd4 || exc_code == 5'd5));

    assert_exc_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rsp_valid);

    assert_one_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || exc_valid) |=> (!rsp_valid && !exc_valid && req_ready));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we || rsp_valid || exc_valid) |-> !req_ready);

    assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_re, mem_we}) <= 1);

endmodule

bind lsu_align_be lsu_align_be_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_addr_lo (mem_addr[1:0]),
    .mem_re      (mem_re),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .rsp_valid   (rsp_valid),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code)
);

// File: tb/lsu_align_be_test.sv
`timescale 1ns/1ps
module lsu_align_be_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_addr;
    logic        mem_re, mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        exc_valid;
    logic [4:0]  exc_code;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem_model [16];
    logic [31:0] ref_mem   [16];
    logic [31:0] rd_q = '0;

    always #2 clk = ~clk;

    lsu_align_be uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .exc_valid(exc_valid), .exc_code(exc_code)
    );

    // Memory model driven by the unit's outputs
    always @(posedge clk) begin
        if (mem_we) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[3-k]) mem_model[mem_addr[5:2]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
        end
        if (mem_re) rd_q <= mem_model[mem_addr[5:2]];
    end
    assign mem_rdata = rd_q;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_load(input logic [5:0] op);
        return op inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25};
    endfunction

    function automatic bit is_store(input logic [5:0] op);
        return op inside {6'h28, 6'h29, 6'h2B};
    endfunction

    function automatic int size_of(input logic [5:0] op);
        if (op inside {6'h20, 6'h24, 6'h28}) return 1;
        if (op inside {6'h21, 6'h25, 6'h29}) return 2;
        return 4;
    endfunction

    function automatic bit misaligned(input logic [5:0] op, input logic [1:0] off);
        if (size_of(op) == 2) return off[0];
        if (size_of(op) == 4) return off != 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [3:0] exp_be(input logic [5:0] op, input logic [1:0] off);
        if (size_of(op) == 1) return 4'b1000 >> off;
        if (size_of(op) == 2) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wword(input logic [5:0] op, input logic [31:0] src);
        if (size_of(op) == 1) return {4{src[7:0]}};
        if (size_of(op) == 2) return {2{src[15:0]}};
        return src;
    endfunction

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [31:0] w, input logic [1:0] off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[31 - 8*off -: 8];
        h = off[1] ? w[15:0] : w[31:16];
        case (op)
            6'h20: return {{24{b[7]}}, b};
            6'h24: return {24'b0, b};
            6'h21: return {{16{h[15]}}, h};
            6'h25: return {16'b0, h};
            default: return w;
        endcase
    endfunction

    task automatic access(input logic [5:0] op, input logic [31:0] base,
                          input logic [15:0] imm, input logic [31:0] wd);
        logic [31:0] ea;
        logic [1:0]  off;
        logic [3:0]  be;
        logic [31:0] m;
        logic [31:0] word_before;
        ea  = base + {{16{imm[15]}}, imm};
        off = ea[1:0];
        chk(req_ready === 1'b1, "R11 ready before request", {31'b0, req_ready}, 32'd1);
        req_op = op; req_base = base; req_imm = imm; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!is_load(op) && !is_store(op)) begin
            chk(!mem_re && !mem_we, "R10 no memory access", {30'b0, mem_re, mem_we}, 32'd0);
            chk(req_ready === 1'b1 && !rsp_valid && !exc_valid, "R10 stays idle",
                {29'b0, req_ready, rsp_valid, exc_valid}, 32'd4);
            @(posedge clk);
            @(negedge clk);
            chk(!rsp_valid && !exc_valid, "R10 no response", {30'b0, rsp_valid, exc_valid}, 32'd0);
            return;
        end
        chk(req_ready === 1'b0, "R11 busy after accept", {31'b0, req_ready}, 32'd0);
        if (misaligned(op, off)) begin
            if (is_store(op)) begin
                chk(!mem_we && mem_be == 4'b0000, "R9 store suppressed", {27'b0, mem_we, mem_be}, 32'd0);
                chk(!mem_re, "R9 no read", {31'b0, mem_re}, 32'd0);
            end else begin
                chk(!mem_re && !mem_we, "R8 no memory access", {30'b0, mem_re, mem_we}, 32'd0);
            end
            @(posedge clk);
            @(negedge clk);
            chk(exc_valid && !rsp_valid, "R8 R9 exception raised", {30'b0, exc_valid, rsp_valid}, 32'd2);
            chk(exc_code == (is_store(op) ? 5'd5 : 5'd4), is_store(op) ? "R9 code" : "R8 code",
                {27'b0, exc_code}, is_store(op) ? 32'd5 : 32'd4);
        end else if (is_store(op)) begin
            be = exp_be(op, off);
            m  = be_mask(be);
            chk(mem_we && !mem_re, "R4 write strobe", {30'b0, mem_we, mem_re}, 32'd2);
            chk(mem_addr == {ea[31:2], 2'b00}, "R1 store address", mem_addr, {ea[31:2], 2'b00});
            chk(mem_be == be, size_of(op) == 1 ? "R2 byte enables" :
                (size_of(op) == 2 ? "R3 half enables" : "R4 word enables"), {28'b0, mem_be}, {28'b0, be});
            chk((mem_wdata & m) == (exp_wword(op, wd) & m), size_of(op) == 1 ? "R2 lane data" :
                (size_of(op) == 2 ? "R3 lane data" : "R4 lane data"), mem_wdata & m, exp_wword(op, wd) & m);
            for (int k = 0; k < 4; k++)
                if (be[3-k]) ref_mem[ea[5:2]][31-8*k -: 8] = exp_wword(op, wd) >> (8*(3-k));
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid && !exc_valid, "R11 store done", {30'b0, rsp_valid, exc_valid}, 32'd2);
        end else begin
            chk(mem_re && !mem_we, "R7 read strobe", {30'b0, mem_re, mem_we}, 32'd2);
            chk(mem_addr == {ea[31:2], 2'b00}, "R1 load address", mem_addr, {ea[31:2], 2'b00});
            word_before = ref_mem[ea[5:2]];
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid && !exc_valid, "R11 load done", {30'b0, rsp_valid, exc_valid}, 32'd2);
            chk(rsp_rdata == exp_load(op, word_before, off), size_of(op) == 1 ? "R5 byte load" :
                (size_of(op) == 2 ? "R6 half load" : "R7 word load"), rsp_rdata, exp_load(op, word_before, off));
        end
        @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid && !exc_valid && req_ready, "R11 single cycle response",
            {29'b0, rsp_valid, exc_valid, req_ready}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [5:0] ops [8];
        logic [5:0] bad_ops [6];
        ops = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2B};
        bad_ops = '{6'h00, 6'h22, 6'h26, 6'h2A, 6'h30, 6'h38};
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = $urandom;
            ref_mem[i]   = mem_model[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1 && !mem_re && !mem_we && mem_be == 4'b0 && !rsp_valid && !exc_valid,
            "R12 reset state", {25'b0, req_ready, mem_re, mem_we, rsp_valid, exc_valid, 2'b0}, 32'h40);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: known word, every op at every offset
        access(6'h2B, 32'h0000_0010, 16'h0000, 32'h80F1_7F02);
        for (int o = 0; o < 8; o++)
            for (int off = 0; off < 4; off++)
                if (is_load(ops[o])) access(ops[o], 32'h0000_0010 + off, 16'h0000, 32'h0);
        for (int o = 0; o < 8; o++)
            for (int off = 0; off < 4; off++)
                if (is_store(ops[o])) begin
                    access(ops[o], 32'h0000_0020 + off, 16'h0000, 32'hA5C3_96E1 + off);
                    access(6'h23, 32'h0000_0020, 16'h0000, 32'h0);
                end
        // Negative immediate and wrap
        access(6'h23, 32'h0000_0100, 16'hFFFC, 32'h0);
        access(6'h28, 32'h0000_0003, 16'hFFFF, 32'h0000_0077);
        access(6'h20, 32'h0000_0000, 16'h0002, 32'h0);
        // Misaligned store followed by read-back of untouched word
        access(6'h29, 32'h0000_0031, 16'h0000, 32'hFFFF_FFFF);
        access(6'h2B, 32'h0000_0032, 16'h0000, 32'hFFFF_FFFF);
        access(6'h23, 32'h0000_0030, 16'h0000, 32'h0);
        access(6'h21, 32'h0000_0033, 16'h0000, 32'h0);
        // Unsupported opcode, then normal access
        access(6'h22, 32'h0000_0010, 16'h0000, 32'h0);
        access(6'h23, 32'h0000_0010, 16'h0000, 32'h0);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0]  op;
            logic [15:0] imm;
            if (($urandom % 16) == 0) op = bad_ops[$urandom % 6];
            else op = ops[$urandom % 8];
            imm = (($urandom % 4) == 0) ? 16'($urandom) : 16'($signed($urandom % 64) - 32);
            access(op, $urandom, imm, $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule